// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block moves a CPU's execution context to and from the stack when an interrupt handler starts and when it returns. The CPU addresses code through a segment register. When an entry strobe is accepted, the block pushes the return program counter and the flags word, one word per cycle. If the frame-mode bit is set, it also pushes the code segment register and then loads that register from the interrupt segment register. If the frame-mode bit is clear, the code segment register is left as it is. For the whole handler, instruction fetch is steered to the interrupt segment register, so the handler stays inside one 64 KB segment.

A return strobe pops the same frame in the opposite order. The frame mode is recorded for each nesting level when entry is accepted. That recorded value, and not the live mode pin, decides the shape of the frame that is popped. The block owns the stack pointer and the code segment register. It gives the segment used for the vector table and the segment that drives fetch. A one-cycle done pulse follows the last transfer of each sequence.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset the block is idle. The stack pointer equals SP_INIT (0x0100), the code segment register is 0, the nesting depth is 0, done is low and fetch uses the code segment register.
- R2: With mode 0, an accepted entry writes the program counter at SP-1 and then the flags at SP-2, zero-extended in the low bits, on consecutive cycles. It leaves the code segment register unchanged.
- R3: With mode 1, an accepted entry writes the program counter at SP-1, the flags at SP-2 and the old code segment register at SP-3, zero-extended. It then loads the code segment register from the interrupt segment register.
- R4: While the innermost active frame is mode 0, fetch uses the interrupt segment register. Software writes to the code segment register change that register but not the fetch segment.
- R5: A return pops in reverse order: the code segment register first (mode 1 frames only), then the flags, then the program counter. The popped program counter and flags appear on the return outputs. A mode-0 return leaves the code segment register untouched.
- R6: Done goes high 3 cycles after the strobe is accepted for mode-0 frames and 4 cycles after for mode-1 frames. This holds for both entry and return.
- R7: The mode is latched for each frame when entry is accepted. Changing the mode pin during the handler does not change the frame that the return pops.
- R8: The stack pointer is decremented before each push and incremented after each pop, one word per transfer. It is back at its starting value once a matching return completes.
- R9: Strobes are ignored in these cases: while a sequence runs, a return with no open frame, and an entry when NEST frames are open. When both strobes are high on an idle cycle, entry is taken.
- R10: The vector segment output always equals the interrupt segment register input.
- R11: Outside any mode-0 frame, a software write to the code segment register takes effect on fetch from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| entry_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Interrupt return strobe |
| mode_i | input | 1 | Frame mode: 1 saves and reloads the code segment register |
| pc_i | input | WORD_W | Return program counter to save |
| flags_i | input | FLAG_W | Flags word to save |
| isr_i | input | SEG_W | Interrupt segment register value |
| csr_we_i | input | 1 | Software write enable for the code segment register |
| csr_wdata_i | input | SEG_W | Software write data for the code segment register |
| stk_rdata_i | input | WORD_W | Stack read data, valid in the cycle of the read |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack word address |
| stk_wdata_o | output | WORD_W | Stack write data |
| sp_o | output | SP_W | Stack pointer |
| csr_o | output | SEG_W | Code segment register |
| fetch_seg_o | output | SEG_W | Segment that drives instruction fetch |
| vec_seg_o | output | SEG_W | Segment of the interrupt vector table |
| busy_o | output | 1 | A push or pop sequence is running |
| done_o | output | 1 | One-cycle pulse after the last transfer |
| depth_o | output | DEPTH_W | Number of open interrupt frames |
| ret_pc_o | output | WORD_W | Program counter restored by the last return |
| ret_flags_o | output | FLAG_W | Flags restored by the last return |

## Verification
The checks assume the stack memory returns read data in the same cycle as the read strobe. They also assume the interrupt segment register is held steady while a mode-0 handler runs idle. The bench's memory model reads combinationally, and the bench changes the interrupt segment only between complete entry and return pairs. Strobes are driven as whole-cycle pulses away from the clock edge. Strobes that land during a sequence or at a depth limit are applied on purpose, because they are part of what is checked.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_POP_CS,
    ST_POP_FL,
    ST_POP_PC
  } seq_state_e;
endpackage

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
  import irq_ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_go,
  input  logic       ret_go,
  input  logic       entry_mode,
  input  logic       ret_mode,
  output seq_state_e state_o,
  output logic       push_en,
  output logic       pop_en,
  output logic       last_xfer,
  output logic       done_o
);
  seq_state_e state_q, state_d;
  logic       fmode_q, fmode_d;
  logic       done_q;

  // next state: transfers run back to back, one per cycle
  always_comb begin
    state_d = state_q;
    fmode_d = fmode_q;
    unique case (state_q)
      ST_IDLE: begin
        if (entry_go) begin
          state_d = ST_PUSH_PC;
          fmode_d = entry_mode;
        end else if (ret_go) begin
          fmode_d = ret_mode;
          state_d = ret_mode ? ST_POP_CS : ST_POP_FL;
        end
      end
      ST_PUSH_PC: state_d = ST_PUSH_FL;
      ST_PUSH_FL: state_d = fmode_q ? ST_PUSH_CS : ST_IDLE;
      ST_PUSH_CS: state_d = ST_IDLE;
      ST_POP_CS:  state_d = ST_POP_FL;
      ST_POP_FL:  state_d = ST_POP_PC;
      ST_POP_PC:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign push_en   = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_FL) ||
                     (state_q == ST_PUSH_CS);
  assign pop_en    = (state_q == ST_POP_CS) || (state_q == ST_POP_FL) ||
                     (state_q == ST_POP_PC);
  assign last_xfer = ((state_q == ST_PUSH_FL) && !fmode_q) ||
                     (state_q == ST_PUSH_CS) || (state_q == ST_POP_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fmode_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fmode_q <= fmode_d;
      done_q  <= last_xfer;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp #(
  parameter int          SP_W    = 16,
  parameter logic [SP_W-1:0] SP_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic            pop_en,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] addr_o
);
  logic [SP_W-1:0] sp_q, sp_d, sp_dec;

  assign sp_dec = sp_q - 1'b1;

  always_comb begin
    sp_d = sp_q;
    if (push_en)     sp_d = sp_dec;
    else if (pop_en) sp_d = sp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_INIT;
    else        sp_q <= sp_d;
  end

  // pre-decrement for writes, post-increment for reads
  assign addr_o = push_en ? sp_dec : sp_q;
  assign sp_o   = sp_q;
endmodule

// File: rtl/irq_ctx_nest.sv
module irq_ctx_nest #(
  parameter int NEST    = 8,
  parameter int DEPTH_W = $clog2(NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               push_mode,
  input  logic               pop,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               top_mode,
  output logic               empty,
  output logic               full
);
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [NEST-1:0]    mode_q;

  always_comb begin
    depth_d = depth_q;
    if (push)     depth_d = depth_q + 1'b1;
    else if (pop) depth_d = depth_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_d;
  end

  // one recorded mode bit per nesting level
  for (genvar i = 0; i < NEST; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mode_q[i] <= 1'b0;
      else if (push && depth_q == DEPTH_W'(i))     mode_q[i] <= push_mode;
    end
  end

  always_comb begin
    top_mode = 1'b0;
    for (int i = 0; i < NEST; i++) begin
      if (depth_q == DEPTH_W'(i + 1)) top_mode = mode_q[i];
    end
  end

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == DEPTH_W'(NEST));
  assign depth_o = depth_q;
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int              WORD_W   = 16,
  parameter int              FLAG_W   = 8,
  parameter int              SEG_W    = 8,
  parameter int              SP_W     = 16,
  parameter int              NEST     = 8,
  parameter logic [SP_W-1:0] SP_INIT  = 16'h0100,
  parameter logic [SEG_W-1:0] CSR_INIT = '0,
  localparam int             DEPTH_W  = $clog2(NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entry_i,
  input  logic               ret_i,
  input  logic               mode_i,
  input  logic [WORD_W-1:0]  pc_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [SEG_W-1:0]   isr_i,
  input  logic               csr_we_i,
  input  logic [SEG_W-1:0]   csr_wdata_i,
  input  logic [WORD_W-1:0]  stk_rdata_i,
  output logic               stk_we_o,
  output logic               stk_re_o,
  output logic [SP_W-1:0]    stk_addr_o,
  output logic [WORD_W-1:0]  stk_wdata_o,
  output logic [SP_W-1:0]    sp_o,
  output logic [SEG_W-1:0]   csr_o,
  output logic [SEG_W-1:0]   fetch_seg_o,
  output logic [SEG_W-1:0]   vec_seg_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [WORD_W-1:0]  ret_pc_o,
  output logic [FLAG_W-1:0]  ret_flags_o
);
  localparam int FL_PAD = WORD_W - FLAG_W;
  localparam int CS_PAD = WORD_W - SEG_W;

  // rst_n is taken as already released in step with clk
  seq_state_e         state;
  logic               push_en, pop_en, last_xfer;
  logic               entry_go, ret_go, pop_done;
  logic               top_mode, empty, full;

  logic [WORD_W-1:0]  pc_cap_q;
  logic [FLAG_W-1:0]  fl_cap_q;
  logic [SEG_W-1:0]   cs_cap_q;
  logic [SEG_W-1:0]   csr_q, csr_d;
  logic [WORD_W-1:0]  ret_pc_q;
  logic [FLAG_W-1:0]  ret_fl_q;

  assign busy_o   = (state != ST_IDLE);
  assign entry_go = !busy_o && entry_i && !full;
  assign ret_go   = !busy_o && !entry_i && ret_i && !empty;
  assign pop_done = pop_en && last_xfer;

  irq_ctx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_go   (entry_go),
    .ret_go     (ret_go),
    .entry_mode (mode_i),
    .ret_mode   (top_mode),
    .state_o    (state),
    .push_en    (push_en),
    .pop_en     (pop_en),
    .last_xfer  (last_xfer),
    .done_o     (done_o)
  );

  irq_ctx_sp #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_en (push_en),
    .pop_en  (pop_en),
    .sp_o    (sp_o),
    .addr_o  (stk_addr_o)
  );

  irq_ctx_nest #(.NEST(NEST), .DEPTH_W(DEPTH_W)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (entry_go),
    .push_mode (mode_i),
    .pop       (pop_done),
    .depth_o   (depth_o),
    .top_mode  (top_mode),
    .empty     (empty),
    .full      (full)
  );

  // frame contents captured on acceptance so later input changes cannot leak in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_cap_q <= '0;
      fl_cap_q <= '0;
      cs_cap_q <= '0;
    end else if (entry_go) begin
      pc_cap_q <= pc_i;
      fl_cap_q <= flags_i;
      cs_cap_q <= csr_q;
    end
  end

  always_comb begin
    unique case (state)
      ST_PUSH_PC: stk_wdata_o = pc_cap_q;
      ST_PUSH_FL: stk_wdata_o = {{FL_PAD{1'b0}}, fl_cap_q};
      ST_PUSH_CS: stk_wdata_o = {{CS_PAD{1'b0}}, cs_cap_q};
      default:    stk_wdata_o = '0;
    endcase
  end

  assign stk_we_o = push_en;
  assign stk_re_o = pop_en;

  // code segment register: sequencer updates take priority over software
  always_comb begin
    csr_d = csr_q;
    if (state == ST_PUSH_CS)     csr_d = isr_i;
    else if (state == ST_POP_CS) csr_d = stk_rdata_i[SEG_W-1:0];
    else if (csr_we_i)           csr_d = csr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= CSR_INIT;
    else        csr_q <= csr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
      ret_fl_q <= '0;
    end else begin
      if (state == ST_POP_FL) ret_fl_q <= stk_rdata_i[FLAG_W-1:0];
      if (state == ST_POP_PC) ret_pc_q <= stk_rdata_i;
    end
  end

  assign fetch_seg_o = (!empty && !top_mode) ? isr_i : csr_q;
  assign vec_seg_o   = isr_i;
  assign csr_o       = csr_q;
  assign ret_pc_o    = ret_pc_q;
  assign ret_flags_o = ret_fl_q;
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
  parameter int SP_W    = 16,
  parameter int SEG_W   = 8,
  parameter int NEST    = 8,
  parameter int DEPTH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               entry_i,
  input logic               ret_i,
  input logic               stk_we_o,
  input logic               stk_re_o,
  input logic [SP_W-1:0]    sp_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               top_mode,
  input logic [SEG_W-1:0]   isr_i,
  input logic [SEG_W-1:0]   fetch_seg_o
);
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we_o && stk_re_o)); // R8
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we_o |=> (sp_o == SP_W'($past(sp_o) - 1'b1))); // R8
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re_o |=> (sp_o == SP_W'($past(sp_o) + 1'b1))); // R8
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_we_o && !stk_re_o) |=> $stable(sp_o)); // R8
  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(stk_we_o || stk_re_o)); // R6
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DEPTH_W'(NEST)); // R9
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !entry_i && ret_i && depth_o == '0) |=> !busy_o); // R9
  AST_M0_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && depth_o != '0 && !top_mode && !entry_i && !ret_i)
      |=> (fetch_seg_o == $past(isr_i))); // R4
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(
  .SP_W(SP_W), .SEG_W(SEG_W), .NEST(NEST), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .entry_i     (entry_i),
  .ret_i       (ret_i),
  .stk_we_o    (stk_we_o),
  .stk_re_o    (stk_re_o),
  .sp_o        (sp_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .depth_o     (depth_o),
  .top_mode    (top_mode),
  .isr_i       (isr_i),
  .fetch_seg_o (fetch_seg_o)
);

// File: tb/irq_ctx_seq_bench.sv
module irq_ctx_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_i, ret_i, mode_i, csr_we_i;
  logic [15:0] pc_i;
  logic [7:0]  flags_i, isr_i, csr_wdata_i;
  logic [15:0] stk_rdata_i;
  logic        stk_we_o, stk_re_o, busy_o, done_o;
  logic [15:0] stk_addr_o, stk_wdata_o, sp_o, ret_pc_o;
  logic [7:0]  csr_o, fetch_seg_o, vec_seg_o, ret_flags_o;
  logic [3:0]  depth_o;

  logic [15:0] mem [0:255];
  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctx_seq u_irq_ctx_seq (
    .clk(clk), .rst_n(rst_n), .entry_i(entry_i), .ret_i(ret_i), .mode_i(mode_i),
    .pc_i(pc_i), .flags_i(flags_i), .isr_i(isr_i), .csr_we_i(csr_we_i),
    .csr_wdata_i(csr_wdata_i), .stk_rdata_i(stk_rdata_i), .stk_we_o(stk_we_o),
    .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o), .stk_wdata_o(stk_wdata_o),
    .sp_o(sp_o), .csr_o(csr_o), .fetch_seg_o(fetch_seg_o), .vec_seg_o(vec_seg_o),
    .busy_o(busy_o), .done_o(done_o), .depth_o(depth_o), .ret_pc_o(ret_pc_o),
    .ret_flags_o(ret_flags_o)
  );

  always_ff @(posedge clk) if (stk_we_o) mem[stk_addr_o[7:0]] <= stk_wdata_o;
  assign stk_rdata_i = mem[stk_addr_o[7:0]];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_entry(input logic m, input logic [15:0] pc,
                          input logic [7:0] fl, output int lat);
    @(negedge clk);
    entry_i = 1'b1; mode_i = m; pc_i = pc; flags_i = fl;
    @(negedge clk);
    entry_i = 1'b0; ret_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic do_return(output int lat);
    @(negedge clk);
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic set_csr(input logic [7:0] v);
    @(negedge clk);
    csr_we_i = 1'b1; csr_wdata_i = v;
    @(negedge clk);
    csr_we_i = 1'b0;
  endtask

  // {mode, pc, flags, csr, isr}
  localparam logic [40:0] VECS [0:5] = '{
    {1'b0, 16'h1234, 8'hA5, 8'h01, 8'h40},
    {1'b1, 16'hBEEF, 8'h3C, 8'h02, 8'h41},
    {1'b0, 16'h0000, 8'hFF, 8'h7E, 8'h00},
    {1'b1, 16'hFFFF, 8'h00, 8'hFF, 8'hC3},
    {1'b1, 16'h8001, 8'h81, 8'h10, 8'h10},
    {1'b0, 16'h5A5A, 8'h5A, 8'h33, 8'hEE}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : stim
    int lat;
    entry_i = 0; ret_i = 0; mode_i = 0; csr_we_i = 0;
    pc_i = '0; flags_i = '0; isr_i = '0; csr_wdata_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1", "sp", sp_o, 32'h100);
    check("R1", "csr", csr_o, 0);
    check("R1", "depth", depth_o, 0);
    check("R1", "busy/done", {busy_o, done_o}, 0);
    check("R1", "fetch", fetch_seg_o, 0);

    for (int i = 0; i < 6; i++) begin
      logic m; logic [15:0] pc; logic [7:0] fl, cs, is;
      {m, pc, fl, cs, is} = VECS[i];
      set_csr(cs);
      check("R11", "fetch after write", fetch_seg_o, cs);
      isr_i = is;
      do_entry(m, pc, fl, lat);
      check("R6", "entry latency", lat, 3 + m);
      check(m ? "R3" : "R2", "pc word", mem[8'hFF], pc);
      check(m ? "R3" : "R2", "flags word", mem[8'hFE], {8'h00, fl});
      if (m) check("R3", "csr word", mem[8'hFD], {8'h00, cs});
      check("R8", "sp after entry", sp_o, 16'h100 - 16'(2 + m));
      check(m ? "R3" : "R2", "csr in handler", csr_o, m ? is : cs);
      check("R4", "fetch in handler", fetch_seg_o, is);
      check("R10", "vector segment", vec_seg_o, is);
      do_return(lat);
      check("R6", "return latency", lat, 3 + m);
      check("R5", "ret pc", ret_pc_o, pc);
      check("R5", "ret flags", ret_flags_o, fl);
      check("R5", "csr after return", csr_o, cs);
      check("R8", "sp restored", sp_o, 16'h100);
      check("R5", "depth after return", depth_o, 0);
    end

    // R4: code segment writes in a mode-0 handler do not steer fetch
    set_csr(8'h11);
    isr_i = 8'h55;
    do_entry(1'b0, 16'h2000, 8'h01, lat);
    set_csr(8'h77);
    check("R4", "fetch ignores csr write", fetch_seg_o, 8'h55);
    check("R4", "csr holds written value", csr_o, 8'h77);
    do_return(lat);
    check("R5", "mode0 return keeps csr", csr_o, 8'h77);
    check("R11", "fetch back on csr", fetch_seg_o, 8'h77);

    // R7: mode pin flipped mid-handler
    isr_i = 8'h90;
    do_entry(1'b1, 16'h3000, 8'h02, lat);
    mode_i = 1'b0;
    do_return(lat);
    check("R7", "return latency with latched mode", lat, 4);
    check("R7", "csr restored", csr_o, 8'h77);
    check("R7", "sp restored", sp_o, 16'h100);

    // R9: return with no open frame
    @(negedge clk); ret_i = 1'b1;
    @(negedge clk); ret_i = 1'b0;
    check("R9", "empty return busy", busy_o, 0);
    @(negedge clk);
    check("R9", "empty return sp", sp_o, 16'h100);

    // R9: entry repeated while busy
    @(negedge clk); entry_i = 1'b1; mode_i = 1'b0; pc_i = 16'h4000;
    @(negedge clk);
    @(negedge clk); entry_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "busy entry ignored depth", depth_o, 1);
    check("R9", "busy entry ignored sp", sp_o, 16'h0FE);
    do_return(lat);
    check("R9", "single return sp", sp_o, 16'h100);

    // R9: entry and return together, entry wins
    @(negedge clk); entry_i = 1'b1; ret_i = 1'b1; mode_i = 1'b0; pc_i = 16'h4444;
    @(negedge clk); entry_i = 1'b0; ret_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "entry wins depth", depth_o, 1);
    do_return(lat);
    check("R9", "entry wins pc", ret_pc_o, 16'h4444);

    // R9: nesting limit and LIFO order
    for (int k = 0; k < 8; k++) do_entry(1'b0, 16'(16'h0A00 + k), 8'(k), lat);
    check("R9", "full depth", depth_o, 8);
    @(negedge clk); entry_i = 1'b1; pc_i = 16'hDEAD;
    @(negedge clk); entry_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "over-limit entry depth", depth_o, 8);
    check("R9", "over-limit entry sp", sp_o, 16'h0F0);
    for (int k = 7; k >= 0; k--) begin
      do_return(lat);
      check("R5", "nested ret pc", ret_pc_o, 16'(16'h0A00 + k));
    end
    check("R8", "sp after unwind", sp_o, 16'h100);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule